// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a programmable sum-of-products logic device. The device has eight such cells, and each copy is told its position by a parameter. The cell takes eight product-term lines from the AND array. It combines them in an OR gate, passes the result through a programmable polarity stage, and either drives the result straight to its pad or first captures it in a flip-flop. It also sends one feedback line back into the AND array.

Three configuration inputs pick one of four working modes: registered output, combinational I/O, dedicated output and dedicated input. The first two are global bits shared by all cells, and the third is the cell's own mode bit. The mode controls four selections inside the cell: which product terms reach the OR gate, what enables the pad driver, what drives the pad value, and where the feedback comes from. A fourth input, the cell's own polarity bit, inverts the data in every mode.

The pad is modelled as a separate value output and enable output. The two end cells choose their feedback from the inverse of the register-permission bit. At device level, their neighbour input is the clock pin or the OE pin. Two middle cells present no feedback in dedicated-output mode.

Mode states and how they are entered (G0 = register-permission bit, G1 = device-style bit, L0 = cell mode bit):
- REGOUT: G1=1, L0=0, G0=0.
- COMBIO: G1=1 with either L0=1, or L0=0 and G0=1.
- DEDOUT: G1=0, L0=0.
- DEDIN: G1=0, L0=1.

A change of mode takes effect in the same cycle as the configuration change. The only stored state is the data flip-flop.

Top module: `pld_out_cell`

## Requirements
- R1: The pad enable follows the mode. In REGOUT it equals the OE pin. In COMBIO it equals product term 0. In DEDOUT it is 1. In DEDIN it is 0.
- R2: In COMBIO, DEDOUT and DEDIN the pad value is combinational, in the same cycle as its inputs. In COMBIO it is the OR of terms 1 to 7 XOR the polarity bit. In DEDOUT and DEDIN it is the OR of all eight terms XOR the polarity bit.
- R3: In REGOUT the pad value is the flip-flop output. At every rising clock edge the flip-flop captures the OR of all eight terms XOR the polarity bit, so a new value appears one cycle after its inputs.
- R4: An active-low asynchronous reset clears the flip-flop to 0.
- R5: When the feedback select is high in REGOUT, the feedback is the flip-flop output.
- R6: When the feedback select is high in any mode other than REGOUT, the feedback is the cell's own pad input.
- R7: When the feedback select is low, the feedback is the neighbour pad input. The exception is cells 3 and 4 in DEDOUT, which feed back constant 0.
- R8: In cells 1 to 6 the feedback select is G1. In cells 0 and 7 it is the inverse of G0. As a result, an end cell never feeds back its neighbour (the clock or OE pin) while registers are permitted.
- R9: Polarity bit 1 inverts the pad value relative to polarity bit 0 in every data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; the flip-flop captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| pt_i | input | 8 | Product-term lines from the AND array; bit 0 is the enable term |
| oe_pin_i | input | 1 | Global output-enable pin, active high |
| pad_i | input | 1 | Value currently present on this cell's pad |
| adj_pad_i | input | 1 | Value on the neighbouring pad (clock or OE pin for the end cells) |
| cfg_g0 | input | 1 | Global bit: 0 permits registers |
| cfg_g1 | input | 1 | Global bit: 1 selects registered-device style |
| cfg_mode | input | 1 | Local mode bit L0 |
| cfg_pol | input | 1 | Local polarity bit L1, 1 inverts |
| pad_o | output | 1 | Pad drive value |
| pad_oe_o | output | 1 | Pad drive enable |
| fb_o | output | 1 | Feedback line into the AND array |

## Verification
The enable, the combinational pad value and the feedback are all due in the same cycle as the stimulus. The registered pad value is due one rising edge later. The driver applies inputs 1 ns after a rising edge and queues the expected values. For that queued item, the reference flip-flop state already includes the capture at the edge just passed. The monitor compares at the following falling edge, which is after every combinational path has settled and before the next capture. Three copies of the cell (a middle cell, an end cell and a no-feedback cell) receive the same stimulus across all eight configuration codes, both polarities and several term, pad and neighbour patterns.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic [1:0] {
        CM_REGOUT = 2'd0,
        CM_COMBIO = 2'd1,
        CM_DEDOUT = 2'd2,
        CM_DEDIN  = 2'd3
    } cell_mode_e;

endpackage

// File: rtl/pld_mode_decode.sv
module pld_mode_decode
    import pld_cell_pkg::*;
(
    input  logic       g0,
    input  logic       g1,
    input  logic       l0,
    output cell_mode_e mode
);

    always_comb begin
        unique case ({g1, l0})
            2'b10:   mode = g0 ? CM_COMBIO : CM_REGOUT;
            2'b11:   mode = CM_COMBIO;
            2'b00:   mode = CM_DEDOUT;
            default: mode = CM_DEDIN;
        endcase
    end

endmodule

// File: rtl/pld_sum_term.sv
module pld_sum_term
    import pld_cell_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] pt,
    input  cell_mode_e           mode,
    input  logic                 pol,
    output logic                 comb_val,
    output logic                 reg_d
);

    localparam int EN_TERM = 0;

    logic or_all;
    logic or_rest;

    always_comb begin
        or_all  = |pt;
        or_rest = 1'b0;
        for (int i = 0; i < NUM_TERMS; i++) begin
            if (i != EN_TERM) or_rest = or_rest | pt[i];
        end
        comb_val = ((mode == CM_COMBIO) ? or_rest : or_all) ^ pol;
        reg_d    = or_all ^ pol;
    end

endmodule

// File: rtl/pld_out_reg.sv
module pld_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end

    // R4: reset leaves the register cleared on the next sampled cycle
    a_r4_reset_clear: assert property (@(posedge clk)
        !rst_n |-> q == 1'b0);

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NUM_TERMS   = 8,
    parameter int NUM_CELLS   = 8,
    parameter int CELL_IDX    = 1,
    parameter int NOFB_CELL_A = 3,
    parameter int NOFB_CELL_B = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pt_i,
    input  logic                 oe_pin_i,
    input  logic                 pad_i,
    input  logic                 adj_pad_i,
    input  logic                 cfg_g0,
    input  logic                 cfg_g1,
    input  logic                 cfg_mode,
    input  logic                 cfg_pol,
    output logic                 pad_o,
    output logic                 pad_oe_o,
    output logic                 fb_o
);

    localparam bit IS_END  = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
    localparam bit IS_NOFB = (CELL_IDX == NOFB_CELL_A) || (CELL_IDX == NOFB_CELL_B);

    cell_mode_e mode;
    logic       comb_val;
    logic       reg_d;
    logic       q;
    logic       fb_sel_own;
    logic       adj_path;

    pld_mode_decode u_decode (
        .g0   (cfg_g0),
        .g1   (cfg_g1),
        .l0   (cfg_mode),
        .mode (mode)
    );

    pld_sum_term #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .pt       (pt_i),
        .mode     (mode),
        .pol      (cfg_pol),
        .comb_val (comb_val),
        .reg_d    (reg_d)
    );

    pld_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (reg_d),
        .q     (q)
    );

    // Enable and output selection
    always_comb begin
        unique case (mode)
            CM_REGOUT: begin pad_oe_o = oe_pin_i; pad_o = q;        end
            CM_COMBIO: begin pad_oe_o = pt_i[0];  pad_o = comb_val; end
            CM_DEDOUT: begin pad_oe_o = 1'b1;     pad_o = comb_val; end
            default:   begin pad_oe_o = 1'b0;     pad_o = comb_val; end
        endcase
    end

    // Feedback select source depends on cell position
    if (IS_END) begin : g_end_sel
        assign fb_sel_own = ~cfg_g0;
    end else begin : g_mid_sel
        assign fb_sel_own = cfg_g1;
    end

    if (IS_NOFB) begin : g_nofb
        assign adj_path = (mode == CM_DEDOUT) ? 1'b0 : adj_pad_i;
    end else begin : g_adj
        assign adj_path = adj_pad_i;
    end

    always_comb begin
        if (fb_sel_own) fb_o = (mode == CM_REGOUT) ? q : pad_i;
        else            fb_o = adj_path;
    end

    // R1: a dedicated input never drives its pad
    a_r1_din_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_g1 && cfg_mode) |-> !pad_oe_o);

    // R1: registered cell enable follows the OE pin
    a_r1_reg_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_g1 && !cfg_mode && !cfg_g0) |-> (pad_oe_o == oe_pin_i));

    // R3: registered pad shows last cycle's data input
    a_r3_reg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (mode == CM_REGOUT)) |-> (pad_o == $past(reg_d)));

    if (IS_END) begin : g_end_chk
        // R8: with registers permitted the neighbour pin cannot disturb feedback
        a_r8_end_no_adj: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_g0 && $past(!cfg_g0) && $stable(pad_i) && $stable(q)
             && $stable({cfg_g1, cfg_mode})) |-> $stable(fb_o));
    end

    if (IS_NOFB) begin : g_nofb_chk
        // R7: no-feedback cells present 0 in dedicated-output mode
        a_r7_nofb_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_g1 && !cfg_mode) |-> (fb_o == 1'b0));
    end

endmodule

// File: tb/tb_pld_out_cell.sv
module tb_pld_out_cell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pt;
    logic       oe_pin, pad_in, adj_in, g0, g1, l0, l1;
    logic [2:0] out_a, out_b, out_c;

    always #2 clk = ~clk;

    pld_out_cell #(.CELL_IDX(1)) dut (
        .clk(clk), .rst_n(rst_n), .pt_i(pt), .oe_pin_i(oe_pin), .pad_i(pad_in),
        .adj_pad_i(adj_in), .cfg_g0(g0), .cfg_g1(g1), .cfg_mode(l0), .cfg_pol(l1),
        .pad_o(out_a[2]), .pad_oe_o(out_a[1]), .fb_o(out_a[0]));

    pld_out_cell #(.CELL_IDX(0)) dut_end (
        .clk(clk), .rst_n(rst_n), .pt_i(pt), .oe_pin_i(oe_pin), .pad_i(pad_in),
        .adj_pad_i(adj_in), .cfg_g0(g0), .cfg_g1(g1), .cfg_mode(l0), .cfg_pol(l1),
        .pad_o(out_b[2]), .pad_oe_o(out_b[1]), .fb_o(out_b[0]));

    pld_out_cell #(.CELL_IDX(3)) dut_gap (
        .clk(clk), .rst_n(rst_n), .pt_i(pt), .oe_pin_i(oe_pin), .pad_i(pad_in),
        .adj_pad_i(adj_in), .cfg_g0(g0), .cfg_g1(g1), .cfg_mode(l0), .cfg_pol(l1),
        .pad_o(out_c[2]), .pad_oe_o(out_c[1]), .fb_o(out_c[0]));

    typedef struct {
        logic [2:0] ea, eb, ec;
        string      tag_val, tag_oe, tag_fa, tag_fb, tag_fc;
    } exp_t;

    exp_t q_exp[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    logic q_ref = 1'b0;
    logic d_last = 1'b0;

    // Reference: {pad value, enable, feedback}
    function automatic logic [2:0] ref_cell(int idx, logic q);
        logic regm, cio, dout, sum, val, en, fbhi, fb;
        regm = g1 && !l0 && !g0;
        cio  = g1 && !regm;
        dout = !g1 && !l0;
        en   = regm ? oe_pin : (cio ? pt[0] : dout);
        sum  = cio ? (|pt[7:1]) : (|pt);
        val  = regm ? q : (sum ^ l1);
        fbhi = (idx == 0 || idx == 7) ? !g0 : g1;
        if (fbhi) fb = regm ? q : pad_in;
        else      fb = ((idx == 3 || idx == 4) && dout) ? 1'b0 : adj_in;
        return {val, en, fb};
    endfunction

    function automatic string fb_tag(int idx);
        logic fbhi;
        fbhi = (idx == 0 || idx == 7) ? !g0 : g1;
        if (idx == 0 || idx == 7)    return "R8";
        if (fbhi && g1 && !l0 && !g0) return "R5";
        if (fbhi)                     return "R6";
        return "R7";
    endfunction

    task automatic step(input logic rst_v, input logic [7:0] pt_v, input logic oe_v,
                        input logic pad_v, input logic adj_v, input logic [2:0] cfg_v,
                        input logic pol_v);
        exp_t e;
        @(posedge clk);
        #1;
        q_ref = rst_n ? d_last : 1'b0;
        rst_n = rst_v; pt = pt_v; oe_pin = oe_v; pad_in = pad_v; adj_in = adj_v;
        {g0, g1, l0} = cfg_v; l1 = pol_v;
        if (!rst_v) q_ref = 1'b0;
        d_last = (|pt_v) ^ pol_v;
        e.ea = ref_cell(1, q_ref);
        e.eb = ref_cell(0, q_ref);
        e.ec = ref_cell(3, q_ref);
        if (!rst_v)                    e.tag_val = "R4";
        else if (g1 && !l0 && !g0)     e.tag_val = pol_v ? "R3/R9" : "R3";
        else                           e.tag_val = pol_v ? "R2/R9" : "R2";
        e.tag_oe = "R1";
        e.tag_fa = fb_tag(1);
        e.tag_fb = fb_tag(0);
        e.tag_fc = fb_tag(3);
        q_exp.push_back(e);
    endtask

    task automatic cmp(string who, string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, who, act, expv);
        end
    endtask

    // Monitor: compare at the falling edge after the stimulus
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                exp_t e;
                e = q_exp.pop_front();
                cmp("mid.pad", e.tag_val, out_a[2], e.ea[2]);
                cmp("mid.oe",  e.tag_oe,  out_a[1], e.ea[1]);
                cmp("mid.fb",  e.tag_fa,  out_a[0], e.ea[0]);
                cmp("end.pad", e.tag_val, out_b[2], e.eb[2]);
                cmp("end.oe",  e.tag_oe,  out_b[1], e.eb[1]);
                cmp("end.fb",  e.tag_fb,  out_b[0], e.eb[0]);
                cmp("gap.pad", e.tag_val, out_c[2], e.ec[2]);
                cmp("gap.oe",  e.tag_oe,  out_c[1], e.ec[1]);
                cmp("gap.fb",  e.tag_fc,  out_c[0], e.ec[0]);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [6];
        pats = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF, 8'h02};
        rst_n = 1'b0; pt = '0; oe_pin = 0; pad_in = 0; adj_in = 0;
        g0 = 0; g1 = 1; l0 = 0; l1 = 0;
        // R4: reset state in registered mode, data would otherwise load 1
        step(1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0);
        step(1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 3'b010, 1'b0);
        // Registered sequence: R3 one-cycle delay
        step(1'b1, 8'h10, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0);
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 3'b010, 1'b0);
        step(1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 3'b010, 1'b1);
        // Walk every configuration code, polarity and pattern
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 6; k++) begin
                    for (int s = 0; s < 4; s++) begin
                        step(1'b1, pats[k], s[0], s[1], s[0] ^ s[1],
                             3'(c), 1'(p));
                    end
                end
            end
        end
        // R4: asynchronous reset mid-run clears the register
        step(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0);
        step(1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0);
        step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 3'b010, 1'b1);
        step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 3'b010, 1'b1);
        @(posedge clk);
        @(posedge clk);
        while (q_exp.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule